// File: doc/BRIEF.md
# Eight-Function Selectable ALU

A purely combinational arithmetic and logic unit. Two operands of a configurable width enter together with a three-bit function code, and a result comes back in the same cycle. Alongside the result the unit reports four status bits: carry, zero, negative and signed overflow. A sequencing controller can use them to steer branches or multi-word arithmetic.

The three arithmetic functions share one ripple adder built from full-adder cells: addition, subtraction and increment. A small operand-preparation stage feeds that adder either B, the inverse of B or zero, and sets the carry into the lowest cell. Bitwise functions and the transfer function come from a separate logic unit. An output multiplexer picks between the two paths, and a flag generator derives status from whichever path was picked.

Top module: `sel_alu`

## Requirements
- R1: With `sel_i` = 3'b000, `result_o` is (A + B) mod 2^W and `carry_o` is bit W of the full unsigned sum.
- R2: With `sel_i` = 3'b001, `result_o` is (A - B) mod 2^W, computed as A + ~B + 1. `carry_o` is 1 exactly when A >= B taken as unsigned numbers, meaning no borrow.
- R3: With `sel_i` = 3'b010, `result_o` is A AND B. With `sel_i` = 3'b011, it is A OR B.
- R4: With `sel_i` = 3'b100, `result_o` is A XOR B. With `sel_i` = 3'b101, it is the bitwise inverse of A.
- R5: With `sel_i` = 3'b110, `result_o` is (A + 1) mod 2^W. `carry_o` is 1 only when A is all ones.
- R6: With `sel_i` = 3'b111, `result_o` equals A, and B has no effect.
- R7: For the five non-arithmetic codes 3'b010 to 3'b111 except 3'b110, `carry_o` and `ovf_o` are 0.
- R8: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R9: `neg_o` equals bit W-1 of `result_o`.
- R10: For codes 3'b000, 3'b001 and 3'b110, `ovf_o` is 1 exactly when the two's-complement result of A+B, A-B or A+1 falls outside the range -2^(W-1) to 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| sel_i | input | 3 | Function code |
| result_o | output | W | Function result |
| carry_o | output | 1 | Carry out of adder (no-borrow for subtract) |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Most significant result bit |
| ovf_o | output | 1 | Signed overflow of an arithmetic function |

## Verification
The bench uses a four-bit build. It sweeps every pairing of A and B under all eight function codes, so every carry chain length is driven. Sign-boundary pairs tell a correct overflow rule apart from one that looks at carries only. Equal operands under subtract separate the no-borrow carry convention from a borrow convention. The all-ones operand under increment is the only case that may raise carry, and sweeping B under transfer and inverse shows that B has no effect there.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_NOT  = 3'b101,
    OP_INC  = 3'b110,
    OP_PASS = 3'b111
  } alu_op_e;

  // sum bit of a full-adder cell
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // majority carry of a full-adder cell
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  function automatic logic uses_adder(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
  endfunction

  // signed overflow from the operand signs entering the adder
  function automatic logic sign_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/sel_alu_opnd.sv
module sel_alu_opnd
  import sel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   b_eff_o,
  output logic           cin_o
);

  always_comb begin
    unique case (op_i)
      OP_SUB: begin
        b_eff_o = ~b_i;
        cin_o   = 1'b1;
      end
      OP_INC: begin
        b_eff_o = '0;
        cin_o   = 1'b1;
      end
      default: begin
        b_eff_o = b_i;
        cin_o   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sel_alu_adder.sv
module sel_alu_adder
  import sel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar gi = 0; gi < W; gi++) begin : g_cell
    assign sum_o[gi]    = fa_sum(x_i[gi], y_i[gi], chain[gi]);
    assign chain[gi+1]  = fa_carry(x_i[gi], y_i[gi], chain[gi]);
  end

  assign cout_o = chain[W];

endmodule

// File: rtl/sel_alu_logic.sv
module sel_alu_logic
  import sel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      OP_PASS: res_o = a_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/sel_alu_flags.sv
module sel_alu_flags
  import sel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         arith_i,
  input  logic         a_msb_i,
  input  logic         b_eff_msb_i,
  input  logic         cout_i,
  input  logic [W-1:0] res_i,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);

  localparam int MSB = W - 1;

  assign zero_o  = ~|res_i;
  assign neg_o   = res_i[MSB];
  assign carry_o = arith_i & cout_i;
  assign ovf_o   = arith_i & sign_ovf(a_msb_i, b_eff_msb_i, res_i[MSB]);

endmodule

// File: rtl/sel_alu.sv
module sel_alu
  import sel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);

  localparam int MSB = W - 1;

  alu_op_e      op;
  logic         arith_sel;
  logic [W-1:0] b_eff;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] logic_res;

  assign op        = alu_op_e'(sel_i);
  assign arith_sel = uses_adder(op);

  sel_alu_opnd #(.W(W)) opnd_i (
    .op_i    (op),
    .b_i     (b_i),
    .b_eff_o (b_eff),
    .cin_o   (add_cin)
  );

  sel_alu_adder #(.W(W)) adder_i (
    .x_i    (a_i),
    .y_i    (b_eff),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  sel_alu_logic #(.W(W)) logic_i (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (logic_res)
  );

  assign result_o = arith_sel ? add_sum : logic_res;

  sel_alu_flags #(.W(W)) flags_i (
    .arith_i     (arith_sel),
    .a_msb_i     (a_i[MSB]),
    .b_eff_msb_i (b_eff[MSB]),
    .cout_i      (add_cout),
    .res_i       (result_o),
    .carry_o     (carry_o),
    .zero_o      (zero_o),
    .neg_o       (neg_o),
    .ovf_o       (ovf_o)
  );

endmodule

// File: rtl/sel_alu_chk.sv
module sel_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   sel_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         ovf_o,
  input logic         arith_sel
);

  always_comb begin
    if (sel_i == 3'b111) begin
      AST_PASS_EQ_A: assert (result_o == a_i) else $error("transfer mismatch"); // R6
    end
    if (!arith_sel) begin
      AST_NO_CARRY_LOGIC: assert (!carry_o && !ovf_o) else $error("flag on logic op"); // R7
    end
    if (sel_i == 3'b110) begin
      AST_INC_CARRY_ONES: assert (carry_o == (&a_i)) else $error("inc carry"); // R5
    end
    if (sel_i == 3'b001 && a_i == b_i) begin
      AST_SUB_EQUAL: assert (zero_o && carry_o && !ovf_o) else $error("sub equal"); // R2
    end
    if (zero_o) begin
      AST_ZERO_IMPLIES_CLEAR: assert (result_o == '0 && !neg_o) else $error("zero flag"); // R8
    end
    if (sel_i == 3'b101) begin
      AST_NOT_SIGN: assert (neg_o != a_i[W-1]) else $error("not sign"); // R9
    end
    if (sel_i == 3'b000 && a_i[W-1] != b_i[W-1]) begin
      AST_NO_OVERFLOW: assert (!ovf_o) else $error("mixed-sign add overflow"); // R10
    end
  end

endmodule

bind sel_alu sel_alu_chk #(.W(W)) chk_i (
  .a_i       (a_i),
  .b_i       (b_i),
  .sel_i     (sel_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .zero_o    (zero_o),
  .neg_o     (neg_o),
  .ovf_o     (ovf_o),
  .arith_sel (arith_sel)
);

// File: tb/sel_alu_tb.sv
module sel_alu_tb_top;

  localparam int W    = 4;
  localparam int MOD  = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [2:0]   sel;
  logic         cy, zf, nf, vf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  sel_alu #(.W(W)) dut_i (
    .a_i(a), .b_i(b), .sel_i(sel),
    .result_o(res), .carry_o(cy), .zero_o(zf), .neg_o(nf), .ovf_o(vf)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (sel=%0d a=%0d b=%0d)",
               tag, what, act, exp, sel, a, b);
    end
  endtask

  function automatic int to_s(input int u);
    return (u >= HALF) ? u - MOD : u;
  endfunction

  function automatic bit out_of_range(input int v);
    return (v < -HALF) || (v > HALF - 1);
  endfunction

  initial begin
    a = '0; b = '0; sel = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res == '0, "R8", "initial result", int'(res), 0);
    chk(zf == 1'b1, "R8", "initial zero",  int'(zf), 1);
    rst = 1'b0;
    for (int op = 0; op < 8; op++) begin
      for (int ia = 0; ia < MOD; ia++) begin
        for (int ib = 0; ib < MOD; ib++) begin
          int full, er, ec, ev;
          string rtag, ctag;
          @(posedge clk);
          sel = op[2:0];
          a   = ia[W-1:0];
          b   = ib[W-1:0];
          ec = 0; ev = 0;
          case (op)
            0: begin full = ia + ib; er = full % MOD; ec = full / MOD;
                     ev = out_of_range(to_s(ia) + to_s(ib)); rtag = "R1"; ctag = "R1"; end
            1: begin er = (ia - ib + MOD) % MOD; ec = (ia >= ib);
                     ev = out_of_range(to_s(ia) - to_s(ib)); rtag = "R2"; ctag = "R2"; end
            2: begin er = ia & ib; rtag = "R3"; ctag = "R7"; end
            3: begin er = ia | ib; rtag = "R3"; ctag = "R7"; end
            4: begin er = ia ^ ib; rtag = "R4"; ctag = "R7"; end
            5: begin er = (MOD - 1) - ia; rtag = "R4"; ctag = "R7"; end
            6: begin er = (ia + 1) % MOD; ec = (ia == MOD - 1);
                     ev = out_of_range(to_s(ia) + 1); rtag = "R5"; ctag = "R5"; end
            default: begin er = ia; rtag = "R6"; ctag = "R7"; end
          endcase
          @(negedge clk);
          chk(int'(res) == er, rtag, "result", int'(res), er);
          chk(int'(cy) == ec, ctag, "carry", int'(cy), ec);
          chk(int'(vf) == ev, (op == 0 || op == 1 || op == 6) ? "R10" : "R7",
              "overflow", int'(vf), ev);
          chk(int'(zf) == (er == 0), "R8", "zero", int'(zf), int'(er == 0));
          chk(int'(nf) == (er / HALF), "R9", "negative", int'(nf), er / HALF);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule